// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the 32-bit program counter of a simple in-order core and picks the address fetched next. Every cycle it looks at the instruction word currently at the PC and at the two source register values the register file supplies for that instruction. From these it decides whether control leaves the sequential path. Three kinds of transfer are decoded by exact opcode and function values: a conditional branch relative to the following instruction, an absolute jump inside the current 256 MB segment, and a jump through a register.

The transfer decision appears on `taken` in the same cycle, from combinational logic. The selected address is loaded into the PC at the next rising clock edge unless `stall` is high, in which case the PC keeps its value. A synchronous reset loads a fixed, word-aligned reset vector, zero by default. Fetching, register reads and link-register writes all belong to the surrounding pipeline.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes the reset vector (default 0x00000000) at that edge.
- R2: An instruction that is not a decoded transfer, or a branch whose condition fails, leaves `taken` low and makes the next PC equal PC+4. This includes opcode 0 with a function code other than 8, and opcode 3.
- R3: While `stall` is high, the PC keeps its value across the edge. `taken` still shows the decision for the presented instruction.
- R4: Opcode 2 (bits 31:26) is an absolute jump. It sets `taken`, and the next PC is bits 31:28 of PC+4, then the 26-bit field in bits 25:0, then two zero bits. The segment comes from PC+4, so a jump in the last word of a segment lands in the following segment.
- R5: Opcode 0 with function code 8 (bits 5:0) is a register jump. It sets `taken`, and the next PC is the `rs_val` value.
- R6: Opcode 4 branches when `rs_val` equals `rt_val`.
- R7: Opcode 5 branches when `rs_val` differs from `rt_val`.
- R8: Opcode 1 branches when `rs_val` is negative as a two's-complement number and the rt field (bits 20:16) is zero. With any nonzero rt field, it counts as a non-transfer.
- R9: A taken branch goes to PC+4 plus the 16-bit field in bits 15:0, sign-extended and multiplied by 4. Negative offsets wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC when high |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Value of the register named by bits 25:21 |
| rt_val | input | 32 | Value of the register named by bits 20:16 |
| pc | output | 32 | Current program counter |
| taken | output | 1 | High when the presented instruction transfers control |

## Verification
The PC register is the block's only state, so any fault in the target or selection logic shows up on `pc` one edge after the instruction is presented. Every later address is offset from the bad one, and the error carries forward through the whole sequence. A bad decode appears on `taken` in the same cycle, before the edge. The bench runs one unbroken PC sequence from reset, so a single wrong target makes every later expected address miss. Stall and mid-run reset are checked at the edge they affect.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int INSN_W = 32;

   localparam logic [5:0] OP_SPECIAL = 6'd0;
   localparam logic [5:0] OP_BLTZ    = 6'd1;
   localparam logic [5:0] OP_JUMP    = 6'd2;
   localparam logic [5:0] OP_BEQ     = 6'd4;
   localparam logic [5:0] OP_BNE     = 6'd5;
   localparam logic [5:0] FN_JREG    = 6'd8;

   typedef enum logic [1:0] {
      XF_SEQ  = 2'd0,
      XF_BR   = 2'd1,
      XF_JMP  = 2'd2,
      XF_JREG = 2'd3
   } xfer_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int W            = 32,
   parameter bit STRICT_SIGNB = 1'b1
) (
   input  logic [5:0]   op,
   input  logic [5:0]   fn,
   input  logic [4:0]   rt_fld,
   input  logic [W-1:0] rs_val,
   input  logic [W-1:0] rt_val,
   output xfer_e        kind
);
   logic same;
   logic sign_ok;

   assign same = (rs_val == rt_val);

   generate
      if (STRICT_SIGNB) begin : g_strict
         assign sign_ok = (rt_fld == 5'd0);
      end else begin : g_loose
         logic unused_rt;
         assign unused_rt = ^rt_fld;
         assign sign_ok   = 1'b1;
      end
   endgenerate

   always_comb begin
      kind = XF_SEQ;
      unique case (op)
         OP_SPECIAL: if (fn == FN_JREG)            kind = XF_JREG;
         OP_BLTZ:    if (sign_ok && rs_val[W-1])   kind = XF_BR;
         OP_JUMP:                                  kind = XF_JMP;
         OP_BEQ:     if (same)                     kind = XF_BR;
         OP_BNE:     if (!same)                    kind = XF_BR;
         default:                                  kind = XF_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int W       = 32,
   parameter int FIELD_W = 26
) (
   input  logic [W-1:0]       pc,
   input  logic [FIELD_W-1:0] tfield,
   input  logic [W-1:0]       rs_val,
   input  xfer_e              kind,
   output logic [W-1:0]       next_pc
);
   localparam int SEG_W = W - FIELD_W - 2;
   localparam int EXT_W = W - 18;

   logic [W-1:0] pc_inc;
   logic [W-1:0] br_dest;
   logic [W-1:0] jmp_dest;
   logic [15:0]  offs;

   assign offs     = tfield[15:0];
   assign pc_inc   = pc + W'(4);
   assign br_dest  = pc_inc + {{EXT_W{offs[15]}}, offs, 2'b00};
   assign jmp_dest = {pc_inc[W-1 -: SEG_W], tfield, 2'b00};

   always_comb begin
      unique case (kind)
         XF_BR:   next_pc = br_dest;
         XF_JMP:  next_pc = jmp_dest;
         XF_JREG: next_pc = rs_val;
         default: next_pc = pc_inc;
      endcase
   end
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
   parameter int          W         = 32,
   parameter logic [31:0] RESET_VEC = 32'h0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= RESET_VEC[W-1:0];
      else if (!hold) q <= d;
   end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
   import npc_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter logic [31:0] RESET_VEC    = 32'h0000_0000,
   parameter bit          STRICT_SIGNB = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        stall,
   input  logic [31:0] instr,
   input  logic [31:0] rs_val,
   input  logic [31:0] rt_val,
   output logic [31:0] pc,
   output logic        taken
);
   localparam int FIELD_W = 26;

   generate
      if (ADDR_W != INSN_W) begin : g_bad_width
         $error("nextpc_unit: ADDR_W must equal the instruction width");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("nextpc_unit: RESET_VEC must be word aligned");
      end
   endgenerate

   xfer_e       kind;
   logic [31:0] next_pc;

   npc_decode #(.W(ADDR_W), .STRICT_SIGNB(STRICT_SIGNB)) u_dec (
      .op     (instr[31:26]),
      .fn     (instr[5:0]),
      .rt_fld (instr[20:16]),
      .rs_val (rs_val),
      .rt_val (rt_val),
      .kind   (kind)
   );

   npc_target #(.W(ADDR_W), .FIELD_W(FIELD_W)) u_tgt (
      .pc      (pc),
      .tfield  (instr[FIELD_W-1:0]),
      .rs_val  (rs_val),
      .kind    (kind),
      .next_pc (next_pc)
   );

   npc_pcreg #(.W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
      .clk  (clk),
      .rst  (rst),
      .hold (stall),
      .d    (next_pc),
      .q    (pc)
   );

   assign taken = (kind != XF_SEQ);
endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
   parameter logic [31:0] RESET_VEC = 32'h0
) (
   input logic        clk,
   input logic        rst,
   input logic        stall,
   input logic [31:0] instr,
   input logic [31:0] rs_val,
   input logic [31:0] rt_val,
   input logic [31:0] pc,
   input logic        taken
);
   logic [5:0]  op;
   logic [31:0] seg_jump;

   assign op       = instr[31:26];
   assign seg_jump = {pc[31:28] + 4'(&pc[27:2]), instr[25:0], 2'b00};

   assert_reset_vec_R1: assert property (@(posedge clk)
      rst |=> pc == RESET_VEC);

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      (!taken && !stall) |=> pc == $past(pc) + 32'd4);

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc));

   assert_jump_seg_R4: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd2 && !stall) |=> pc == $past(seg_jump));

   assert_jreg_dest_R5: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd0 && instr[5:0] == 6'd8 && !stall) |=> pc == $past(rs_val));

   assert_beq_equal_R6: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd4 && rs_val == rt_val) |-> taken);

   assert_bne_equal_R7: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd5 && rs_val == rt_val) |-> !taken);

   assert_signb_rt_R8: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd1 && instr[20:16] != 5'd0) |-> !taken);
endmodule

bind nextpc_unit npc_checker #(.RESET_VEC(RESET_VEC)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .stall  (stall),
   .instr  (instr),
   .rs_val (rs_val),
   .rt_val (rt_val),
   .pc     (pc),
   .taken  (taken)
);

// File: tb/tb_nextpc_unit.sv
`timescale 1ns/1ps
module tb_nextpc_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_val = 32'h0;
   logic [31:0] rt_val = 32'h0;
   logic [31:0] pc;
   logic        taken;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   nextpc_unit dut (
      .clk(clk), .rst(rst), .stall(stall), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .taken(taken)
   );

   typedef struct packed {
      logic [31:0] ins;
      logic [31:0] rsv;
      logic [31:0] rtv;
      logic        tk;
      logic [31:0] nxt;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0020, 32'h1,         32'h2,         1'b0, 32'h0000_0004}, // R2 add
      '{32'h1000_0003, 32'h5,         32'h5,         1'b1, 32'h0000_0014}, // R6 beq hit
      '{32'h1000_0003, 32'h5,         32'h6,         1'b0, 32'h0000_0018}, // R6 beq miss
      '{32'h1400_FFFE, 32'h3,         32'h4,         1'b1, 32'h0000_0014}, // R7 R9 back
      '{32'h1400_0005, 32'h7,         32'h7,         1'b0, 32'h0000_0018}, // R7 miss
      '{32'h0400_0004, 32'h8000_0000, 32'h0,         1'b1, 32'h0000_002C}, // R8 neg
      '{32'h0400_0004, 32'h0,         32'h0,         1'b0, 32'h0000_0030}, // R8 zero
      '{32'h0401_0004, 32'hFFFF_FFFF, 32'h0,         1'b0, 32'h0000_0034}, // R8 rt!=0
      '{32'h0000_0008, 32'h0000_1000, 32'h0,         1'b1, 32'h0000_1000}, // R5
      '{32'h0000_0009, 32'h0000_5000, 32'h0,         1'b0, 32'h0000_1004}, // R2 fn 9
      '{32'h0000_0008, 32'hF000_0010, 32'h0,         1'b1, 32'hF000_0010}, // R5
      '{32'h0800_0040, 32'h0,         32'h0,         1'b1, 32'hF000_0100}, // R4
      '{32'h8C00_0000, 32'h0,         32'h0,         1'b0, 32'hF000_0104}, // R2 load
      '{32'h0C00_0010, 32'h0,         32'h0,         1'b0, 32'hF000_0108}, // R2 op 3
      '{32'h1000_8000, 32'h0,         32'h0,         1'b1, 32'hEFFE_010C}, // R9 min
      '{32'h0BFF_FFFF, 32'h0,         32'h0,         1'b1, 32'hEFFF_FFFC}, // R4 max field
      '{32'h0800_0001, 32'h0,         32'h0,         1'b1, 32'hF000_0004}  // R4 seg edge
   };

   function automatic string tag_of(logic [31:0] w);
      case (w[31:26])
         6'd0:    return (w[5:0] == 6'd8) ? "R5" : "R2";
         6'd1:    return "R8";
         6'd2:    return "R4";
         6'd4:    return "R6";
         6'd5:    return "R7";
         default: return "R2";
      endcase
   endfunction

   task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      check32("R1", "pc after reset", pc, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         instr  = VECS[i].ins;
         rs_val = VECS[i].rsv;
         rt_val = VECS[i].rtv;
         #1;
         check32(tag_of(VECS[i].ins), "taken", 32'(taken), 32'(VECS[i].tk));
         @(posedge clk);
         #1;
         check32(tag_of(VECS[i].ins), "next pc", pc, VECS[i].nxt);
         @(negedge clk);
      end

      // R3: stall holds pc for two edges while a jump is presented
      stall  = 1'b1;
      instr  = 32'h0800_0100;
      #1;
      check32("R3", "taken under stall", 32'(taken), 32'h1);
      repeat (2) @(posedge clk);
      #1;
      check32("R3", "pc held", pc, 32'hF000_0004);
      @(negedge clk);
      stall = 1'b0;
      @(posedge clk);
      #1;
      check32("R4", "jump after stall", pc, 32'hF000_0400);

      // R1: reset in mid-run overrides a pending jump register
      @(negedge clk);
      rst    = 1'b1;
      instr  = 32'h0000_0008;
      rs_val = 32'h1234_5678;
      @(posedge clk);
      #1;
      check32("R1", "mid-run reset", pc, 32'h0);
      @(negedge clk);
      rst   = 1'b0;
      instr = 32'h0000_0000;
      @(posedge clk);
      #1;
      check32("R2", "step after reset", pc, 32'h4);
      finish_up();
   end
endmodule